// File: doc/BRIEF.md
# Bit-Group Permutation Unit (reverse, OR-combine, zip/unzip)

This block rearranges the bits of a 64-bit operand under a small control value. It has four modes. Generalized reverse swaps neighbouring bit groups of sizes 1, 2, 4, 8, 16 and 32, one size per control bit. OR-combine runs the same swaps but merges each swapped copy into the running value with OR, so every selected group is smeared across its partner. Zip (shuffle) interleaves the halves of bit groups, and unzip (unshuffle) undoes it. An execution pipeline feeds one operation per cycle. The result comes out of a single output register one clock after the inputs are presented.

All four modes share one chain of butterfly stages. Each stage position takes one of several operations: pass, swap, swap-and-OR, or a zip step at a chosen distance. A small decoder chooses that operation from the mode, the control bits and the word flag. A word flag selects 32-bit operation. The upper half of the operand is then ignored, fewer control bits take effect and the upper half of the result is zero.

Top module: `perm_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge the result register loads zero. Otherwise the result present after an edge is the function of the inputs sampled at that edge, so there is one cycle of latency.
- R2: Mode 2'b00 (reverse). For each control bit k that is set (k = 0..5, ascending), bit groups of size 2^k swap with their neighbour. This means bit i moves to bit i XOR 2^k.
- R3: Mode 2'b01 (OR-combine). The stages are the same as in R2, but each enabled stage ORs the swapped value into the current value. Every input bit therefore stays set in the result.
- R4: Mode 2'b10 (zip). For control bits k = 4 down to 0, in that order, a set bit applies a stage of distance N = 2^k. The stage keeps every bit outside maskL|maskR. It then places (x<<N)&maskL and (x>>N)&maskR. Bit i of maskL is set when i[k+1]=1 and i[k]=0. Bit i of maskR is set when i[k+1]=0 and i[k]=1.
- R5: Mode 2'b11 (unzip). It uses the stages of R4 in ascending order, k = 0 up to 4. For every control value, unzip of the zip result returns the original operand, both in 64-bit and in 32-bit operation.
- R6: With `half_i` high, only operand bits 31..0 take part and result bits 63..32 are zero. Operand bits 63..32 have no effect.
- R7: In 32-bit operation, reverse and OR-combine use control bits 4..0 only. Zip and unzip use control bits 3..0 only. The remaining control bits have no effect. In 64-bit operation, zip and unzip ignore control bit 5.
- R8: Applying reverse twice with the same control returns the original operand, for all 64 control values.
- R9: Reverse, zip and unzip in 64-bit operation preserve the number of set bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | DATA_W (64) | Data to permute |
| control_i | input | $clog2(DATA_W) (6) | Stage enables: bit k selects group size or distance 2^k |
| mode_i | input | 2 | 00 reverse, 01 OR-combine, 10 zip, 11 unzip |
| half_i | input | 1 | High selects 32-bit operation on the low half |
| result_o | output | DATA_W (64) | Registered result |

## Verification
The output register shows one vector's result while the decoder is already steering the stage chain for the next vector. These two vectors can be in different modes, for example a zip result leaving while an unzip or an OR-combine is entering. The same applies when the word flag toggles. The bench provokes this by streaming vectors back to back, changing the mode and the word flag every cycle. A scoreboard compares each cycle's output against an independent model of the vector issued one edge earlier. Round trips (zip then unzip, reverse twice) feed the design's own output back in, and must recover the original operand.

// File: rtl/perm_pkg.sv
package perm_pkg;

  // Operation selected at the block's edge.
  typedef enum logic [1:0] {
    MODE_REV   = 2'b00,
    MODE_ORC   = 2'b01,
    MODE_ZIP   = 2'b10,
    MODE_UNZIP = 2'b11
  } perm_mode_e;

  // Operation performed by one position of the butterfly chain.
  typedef enum logic [2:0] {
    ST_PASS     = 3'd0,
    ST_SWAP     = 3'd1,
    ST_ORSW     = 3'd2,
    ST_UNZIP    = 3'd3,
    ST_ZIP_FULL = 3'd4,
    ST_ZIP_HALF = 3'd5
  } stage_op_e;

endpackage

// File: rtl/perm_decode.sv
module perm_decode
  import perm_pkg::*;
#(
  parameter int W = 64
) (
  input  perm_mode_e         mode_i,
  input  logic [$clog2(W)-1:0] ctl_i,
  input  logic               half_i,
  output stage_op_e          op_o [$clog2(W)]
);

  localparam int LW     = $clog2(W);
  localparam int S_FULL = LW - 1;   // zip stages in full width
  localparam int S_HALF = LW - 2;   // zip stages in half width

  for (genvar p = 0; p < LW; p++) begin : g_pos
    localparam int  KF    = S_FULL - 1 - p;  // zip stage run here, full width
    localparam int  KH    = S_HALF - 1 - p;  // zip stage run here, half width
    localparam bit  SW_H  = (p < LW - 1);    // swap allowed in half width
    localparam bit  UZ_F  = (p < S_FULL);
    localparam bit  UZ_H  = (p < S_HALF);

    logic      zf_on;
    logic      zh_on;
    stage_op_e op_p;

    if (p < S_FULL) begin : g_zf
      assign zf_on = ctl_i[KF];
    end else begin : g_zf_off
      assign zf_on = 1'b0;
    end

    if (p < S_HALF) begin : g_zh
      assign zh_on = ctl_i[KH];
    end else begin : g_zh_off
      assign zh_on = 1'b0;
    end

    always_comb begin
      op_p = ST_PASS;
      unique case (mode_i)
        MODE_REV: begin
          if (ctl_i[p] && (!half_i || SW_H)) op_p = ST_SWAP;
        end
        MODE_ORC: begin
          if (ctl_i[p] && (!half_i || SW_H)) op_p = ST_ORSW;
        end
        MODE_ZIP: begin
          if (half_i) begin
            if (zh_on) op_p = ST_ZIP_HALF;
          end else begin
            if (zf_on) op_p = ST_ZIP_FULL;
          end
        end
        MODE_UNZIP: begin
          if (ctl_i[p] && (half_i ? UZ_H : UZ_F)) op_p = ST_UNZIP;
        end
        default: op_p = ST_PASS;
      endcase
    end

    assign op_o[p] = op_p;
  end

endmodule

// File: rtl/perm_stage.sv
module perm_stage
  import perm_pkg::*;
#(
  parameter int W   = 64,
  parameter int POS = 0
) (
  input  logic [W-1:0] d_i,
  input  stage_op_e    op_i,
  output logic [W-1:0] d_o
);

  localparam int LW     = $clog2(W);
  localparam int S_FULL = LW - 1;
  localparam int S_HALF = LW - 2;
  localparam int DIST   = 1 << POS;
  localparam int K_UZ   = POS;
  localparam int K_ZF   = S_FULL - 1 - POS;
  localparam int K_ZH   = S_HALF - 1 - POS;

  // Bits whose index has bit POS clear: the lower member of each pair.
  function automatic logic [W-1:0] pair_low_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (((i >> POS) & 1) == 0);
    return m;
  endfunction

  // One zip step of distance 2^k; out-of-range k leaves data untouched.
  function automatic logic [W-1:0] zip_step(input logic [W-1:0] x, input int k);
    logic [W-1:0] ml;
    logic [W-1:0] mr;
    if (k < 0 || k >= S_FULL) return x;
    for (int i = 0; i < W; i++) begin
      ml[i] = (((i >> (k + 1)) & 1) == 1) && (((i >> k) & 1) == 0);
      mr[i] = (((i >> (k + 1)) & 1) == 0) && (((i >> k) & 1) == 1);
    end
    return (x & ~(ml | mr)) | ((x << (1 << k)) & ml) | ((x >> (1 << k)) & mr);
  endfunction

  localparam logic [W-1:0] LO_M = pair_low_mask();

  logic [W-1:0] swapped;
  assign swapped = ((d_i & LO_M) << DIST) | ((d_i & ~LO_M) >> DIST);

  always_comb begin
    unique case (op_i)
      ST_SWAP:     d_o = swapped;
      ST_ORSW:     d_o = d_i | swapped;
      ST_UNZIP:    d_o = zip_step(d_i, K_UZ);
      ST_ZIP_FULL: d_o = zip_step(d_i, K_ZF);
      ST_ZIP_HALF: d_o = zip_step(d_i, K_ZH);
      default:     d_o = d_i;
    endcase
  end

endmodule

// File: rtl/perm_net.sv
module perm_net
  import perm_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] d_i,
  input  stage_op_e    op_i [$clog2(W)],
  output logic [W-1:0] d_o
);

  localparam int LW = $clog2(W);

  logic [W-1:0] tap [LW+1];
  assign tap[0] = d_i;

  for (genvar p = 0; p < LW; p++) begin : g_stage
    perm_stage #(
      .W   (W),
      .POS (p)
    ) u_stage (
      .d_i  (tap[p]),
      .op_i (op_i[p]),
      .d_o  (tap[p+1])
    );
  end

  assign d_o = tap[LW];

endmodule

// File: rtl/perm_unit.sv
module perm_unit
  import perm_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DATA_W-1:0]         operand_i,
  input  logic [$clog2(DATA_W)-1:0] control_i,
  input  logic [1:0]                mode_i,
  input  logic                      half_i,
  output logic [DATA_W-1:0]         result_o
);

  localparam int LW = $clog2(DATA_W);
  localparam int HW = DATA_W / 2;

  perm_mode_e   mode_e;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] net_out;
  stage_op_e    stage_op [LW];
  logic [DATA_W-1:0] result_q;

  assign mode_e = perm_mode_e'(mode_i);

  // Word operation: the upper half never enters the chain.
  assign src = half_i ? {{HW{1'b0}}, operand_i[HW-1:0]} : operand_i;

  perm_decode #(.W(DATA_W)) u_decode (
    .mode_i (mode_e),
    .ctl_i  (control_i),
    .half_i (half_i),
    .op_o   (stage_op)
  );

  perm_net #(.W(DATA_W)) u_net (
    .d_i  (src),
    .op_i (stage_op),
    .d_o  (net_out)
  );

  always_ff @(posedge clk) begin
    if (rst) result_q <= '0;
    else     result_q <= net_out;
  end

  assign result_o = result_q;

  // R1: reset clears the output register
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (result_o == '0));

  // R6: word operation leaves the upper half of the result at zero
  p_half_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    $past(half_i) |-> (result_o[DATA_W-1:HW] == '0));

  // R3: OR-combine never clears an input bit
  p_orc_keeps_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode_i) == 2'b01) && !$past(half_i))
      |-> ((result_o & $past(operand_i)) == $past(operand_i)));

  // R2: reverse with an all-zero control passes the operand through
  p_rev_zero_ctl_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode_i) == 2'b00) && !$past(half_i) && ($past(control_i) == '0))
      |-> (result_o == $past(operand_i)));

  // R9: the pure permutation modes keep the population count
  p_perm_popcount_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode_i) != 2'b01) && !$past(half_i))
      |-> ($countones(result_o) == $countones($past(operand_i))));

endmodule

// File: tb/perm_unit_tb.sv
module perm_unit_tb;

  localparam int W = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd = '0;
  logic [5:0]  ctl = '0;
  logic [1:0]  mode = 2'b00;
  logic        half = 1'b0;
  logic [63:0] res;

  always #4 clk = ~clk;   // 125 MHz

  perm_unit #(.DATA_W(W)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .operand_i (opnd),
    .control_i (ctl),
    .mode_i    (mode),
    .half_i    (half),
    .result_o  (res)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [63:0] exp_q [$];
  string       req_q [$];
  logic [63:0] rng = 64'h9E3779B97F4A7C15;

  // ---------------- reference model ----------------
  function automatic logic [63:0] gmask(input int k);
    case (k)
      0: return 64'h5555555555555555;
      1: return 64'h3333333333333333;
      2: return 64'h0F0F0F0F0F0F0F0F;
      3: return 64'h00FF00FF00FF00FF;
      4: return 64'h0000FFFF0000FFFF;
      default: return 64'h00000000FFFFFFFF;
    endcase
  endfunction

  function automatic logic [63:0] ref_rev(input logic [63:0] a, input logic [5:0] c,
                                          input logic h, input logic orm);
    logic [63:0] x, sw;
    int n;
    x = a;
    n = h ? 5 : 6;
    if (h) x[63:32] = '0;
    for (int k = 0; k < n; k++) begin
      if (c[k]) begin
        sw = ((x & gmask(k)) << (1 << k)) | ((x & ~gmask(k)) >> (1 << k));
        x = orm ? (x | sw) : sw;
      end
    end
    return x;
  endfunction

  function automatic logic [63:0] zstage(input logic [63:0] x, input int k);
    logic [63:0] l, r;
    case (k)
      4: begin l = 64'h0000ffff00000000; r = 64'h00000000ffff0000; end
      3: begin l = 64'h00ff000000ff0000; r = 64'h0000ff000000ff00; end
      2: begin l = 64'h0f000f000f000f00; r = 64'h00f000f000f000f0; end
      1: begin l = 64'h3030303030303030; r = 64'h0c0c0c0c0c0c0c0c; end
      default: begin l = 64'h4444444444444444; r = 64'h2222222222222222; end
    endcase
    return (x & ~(l | r)) | ((x << (1 << k)) & l) | ((x >> (1 << k)) & r);
  endfunction

  function automatic logic [63:0] ref_zip(input logic [63:0] a, input logic [5:0] c,
                                          input logic h, input logic inv);
    logic [63:0] x;
    int n;
    x = a;
    n = h ? 4 : 5;
    if (h) x[63:32] = '0;
    if (inv) begin
      for (int k = 0; k < n; k++) if (c[k]) x = zstage(x, k);
    end else begin
      for (int k = n - 1; k >= 0; k--) if (c[k]) x = zstage(x, k);
    end
    return x;
  endfunction

  function automatic logic [63:0] ref_model(input logic [63:0] a, input logic [5:0] c,
                                            input logic [1:0] m, input logic h);
    case (m)
      2'b00:   return ref_rev(a, c, h, 1'b0);
      2'b01:   return ref_rev(a, c, h, 1'b1);
      2'b10:   return ref_zip(a, c, h, 1'b0);
      default: return ref_zip(a, c, h, 1'b1);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] m, input logic h);
    if (h) return "R6";
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // ---------------- driver / monitor ----------------
  task automatic next_rand(output logic [63:0] v);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
    v = rng;
  endtask

  task automatic drive_exp(input logic [63:0] a, input logic [5:0] c, input logic [1:0] m,
                           input logic h, input logic [63:0] e, input string req);
    @(negedge clk);
    opnd = a; ctl = c; mode = m; half = h;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic drive(input logic [63:0] a, input logic [5:0] c, input logic [1:0] m,
                       input logic h, input string req);
    drive_exp(a, c, m, h, ref_model(a, c, m, h), req);
  endtask

  task automatic drive_get(input logic [63:0] a, input logic [5:0] c, input logic [1:0] m,
                           input logic h, input logic [63:0] e, input string req,
                           output logic [63:0] got);
    drive_exp(a, c, m, h, e, req);
    @(posedge clk);
    #3;
    got = res;
  endtask

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] e);
    n_vec++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: result %h expected %h", req, got, e);
    end
  endtask

  initial begin : monitor
    logic [63:0] e;
    string r;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, res, e);
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin : stim
    logic [63:0] a, b, got, mid, back;
    // R1: reset state with busy inputs
    opnd = '1; ctl = 6'h3f; mode = 2'b01; half = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset", res, 64'h0);
    @(negedge clk);
    rst = 1'b0;

    // Directed literal values
    drive_get(64'h0123456789ABCDEF, 6'h3f, 2'b00, 1'b0, 64'hF7B3D591E6A2C480, "R2 full reverse", got);
    drive_get(64'h0123456789ABCDEF, 6'h38, 2'b00, 1'b0, 64'hEFCDAB8967452301, "R2 byte reverse", got);
    drive_get(64'h0000000100000080, 6'h07, 2'b01, 1'b0, 64'h000000FF000000FF, "R3 byte smear", got);
    drive_get(64'h00000000FFFFFFFF, 6'h1f, 2'b10, 1'b0, 64'h5555555555555555, "R4 full zip", got);
    drive_get(64'h5555555555555555, 6'h1f, 2'b11, 1'b0, 64'h00000000FFFFFFFF, "R5 full unzip", got);
    drive_get(64'hDEADBEEF0000FFFF, 6'h0f, 2'b10, 1'b1, 64'h0000000055555555, "R6 half zip", got);

    // R6/R7: upper operand bits and unused control bits have no effect in word mode
    for (int i = 0; i < 8; i++) begin
      next_rand(a);
      drive_get(a, 6'h15, 2'b00, 1'b1, ref_rev(a, 6'h15, 1'b1, 1'b0), "R6", got);
      drive_get({~a[63:32], a[31:0]}, 6'h35, 2'b00, 1'b1, got, "R7 rev bit5", b);
      drive_get(a, 6'h05, 2'b10, 1'b1, ref_zip(a, 6'h05, 1'b1, 1'b0), "R6", got);
      drive_get(a, 6'h15, 2'b10, 1'b1, got, "R7 zip bit4", b);
      drive_get(a, 6'h2a, 2'b11, 1'b0, ref_zip(a, 6'h0a, 1'b0, 1'b1), "R7 unzip bit5", got);
    end

    // R5: unzip inverts zip for every control value, both widths
    for (int c = 0; c < 32; c++) begin
      next_rand(a);
      drive_get(a, 6'(c), 2'b10, 1'b0, ref_zip(a, 6'(c), 1'b0, 1'b0), "R4", mid);
      drive_get(mid, 6'(c), 2'b11, 1'b0, a, "R5 round trip", back);
    end
    for (int c = 0; c < 16; c++) begin
      next_rand(a);
      drive_get(a, 6'(c), 2'b10, 1'b1, ref_zip(a, 6'(c), 1'b1, 1'b0), "R4 half", mid);
      drive_get(mid, 6'(c), 2'b11, 1'b1, {32'h0, a[31:0]}, "R5 half round trip", back);
    end

    // R8: reverse applied twice restores the operand
    for (int c = 0; c < 64; c++) begin
      next_rand(a);
      drive_get(a, 6'(c), 2'b00, 1'b0, ref_rev(a, 6'(c), 1'b0, 1'b0), "R2", mid);
      drive_get(mid, 6'(c), 2'b00, 1'b0, a, "R8 double reverse", back);
    end

    // Back-to-back stream: mode and word flag change every cycle (R9 via model)
    for (int i = 0; i < 160; i++) begin
      next_rand(a);
      next_rand(b);
      drive(a, b[5:0], 2'(i % 4), b[8] & b[9], req_of(2'(i % 4), b[8] & b[9]));
    end

    @(posedge clk);
    #5;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule